// File: doc/BRIEF.md
# DS1 Transmit Channel Byte Conditioner

This block prepares each 8-bit DS0 channel byte on its way to a DS1 transmitter. With every byte it receives the frame number within the superframe and the four signalling bits of that channel. It then applies four rules in a fixed order. First, it overwrites the least significant bit with a signalling bit on every sixth frame. Second, it clears the alarm bit while the remote alarm is raised. Third, it stops an all-zero byte from being sent when no other ones-density method is in force. Last, it replaces everything with ones when the all-ones alarm is chosen. The conditioned byte is registered and appears one clock after the input.

The block also drives the data-link bit for the framer. In extended-superframe operation with the link alarm set, it sends a repeating run of eight ones followed by eight zeros, one bit per data-link slot. In every other case it passes the external data-link bit through. A separate flag tells the line coder when it must apply eight-zero substitution. The substitution itself, the framing-bit multiplexer and the line coder are outside this block.

Bit 1 is the most significant bit of a byte and is sent first. Bit 8 is the least significant. Bit n is therefore `tx_byte[8-n]`.

Top module: `ds0_tx_conditioner`

## Requirements
- R1: For a frame with `frame_num % 6 == 5`, with `ctl_rbs_dis` low, bit 8 (`tx_byte[0]`) carries a signalling bit. With `ctl_rbs_dis` high, or on any other frame, bit 8 equals the input bit.
- R2: The signalling bit is chosen by `frame_num / 6`. Value 0 selects A (`sig_abcd[3]`), 1 selects B (`sig_abcd[2]`), 2 selects C (`sig_abcd[1]`) and 3 selects D (`sig_abcd[0]`).
- R3: With `ctl_yellow` high, bit 2 (`tx_byte[6]`) is 0. Otherwise bit 2 passes unchanged.
- R4: With both `ctl_transparent` and `ctl_b8zs` low, a byte that is 0x00 after the R1 and R3 rules is sent with bit 7 (`tx_byte[1]`) set, which gives 0x02. No other bit changes.
- R5: With `ctl_transparent` high, no zero suppression is applied, so 0x00 can be sent, and `b8zs_en` is low whatever `ctl_b8zs` is.
- R6: With `ctl_b8zs` high and `ctl_transparent` low, `b8zs_en` is high in the same cycle and the byte is not altered for zero suppression.
- R7: With `ctl_esf` and `ctl_esf_yellow` both high, the data-link slots carry ones on slots 0 to 7 and zeros on slots 8 to 15, repeating. The count advances only on `fdl_slot` cycles and restarts at slot 0 on each rising edge of the combined enable. Otherwise the output is `fdl_in`, sampled in the slot cycle.
- R8: With `ctl_all_ones` high, `tx_byte` is 0xFF and data-link slots send 1, overriding R1 to R7.
- R9: `out_valid` and `tx_byte` follow `in_valid` one clock later. `fdl_out` updates only in the clock after an `fdl_slot` cycle and holds at all other times.
- R10: During reset, `out_valid` is 0, `tx_byte` is 0xFF and `fdl_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Channel byte present this cycle |
| ch_in | input | 8 | Channel byte, bit 1 in the MSB |
| frame_num | input | FRM_W (5) | Frame number within the superframe, 0 to 23 |
| sig_abcd | input | SIG_BITS (4) | Signalling bits A (MSB) to D (LSB) for this channel |
| ctl_rbs_dis | input | 1 | Disable signalling insertion |
| ctl_yellow | input | 1 | Remote alarm: clear bit 2 |
| ctl_transparent | input | 1 | No zero-code suppression |
| ctl_b8zs | input | 1 | Eight-zero substitution selected |
| ctl_esf | input | 1 | Extended-superframe operation |
| ctl_esf_yellow | input | 1 | Send the link alarm pattern |
| ctl_all_ones | input | 1 | Send unframed all ones |
| fdl_slot | input | 1 | Current cycle is a data-link bit slot |
| fdl_in | input | 1 | External data-link bit |
| out_valid | output | 1 | `tx_byte` holds a new byte |
| tx_byte | output | 8 | Conditioned channel byte |
| fdl_out | output | 1 | Data-link bit to send |
| b8zs_en | output | 1 | Line coder must apply eight-zero substitution |

## Verification
The properties assume that `frame_num` never goes past 23. They also assume that the control inputs change only between bytes, so a byte and the controls that applied to it are seen in the same clock. The properties that compare output to input take `ctl_rbs_dis` high to rule out signalling insertion. The stimulus changes controls and frame numbers only at the falling edge and keeps the frame number within the 24-frame superframe. The sweep covers every combination of the five controls that act on the byte, across all 24 frames, with bytes chosen so that signalling insertion or bit-2 clearing can produce an all-zero byte.

// File: rtl/ds0_tx_conditioner.sv
module ds0_tx_conditioner #(
  parameter int FRAMES_PER_SF = 24,
  parameter int SIG_PERIOD    = 6,
  parameter int YEL_RUN       = 8,
  localparam int FRM_W        = $clog2(FRAMES_PER_SF),
  localparam int SIG_BITS     = FRAMES_PER_SF / SIG_PERIOD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          ch_in,
  input  logic [FRM_W-1:0]    frame_num,
  input  logic [SIG_BITS-1:0] sig_abcd,
  input  logic                ctl_rbs_dis,
  input  logic                ctl_yellow,
  input  logic                ctl_transparent,
  input  logic                ctl_b8zs,
  input  logic                ctl_esf,
  input  logic                ctl_esf_yellow,
  input  logic                ctl_all_ones,
  input  logic                fdl_slot,
  input  logic                fdl_in,
  output logic                out_valid,
  output logic [7:0]          tx_byte,
  output logic                fdl_out,
  output logic                b8zs_en
);
  localparam int SIDX_W = (SIG_BITS > 1) ? $clog2(SIG_BITS) : 1;
  localparam int CNT_W  = $clog2(2 * YEL_RUN);

  logic [SIG_BITS-1:0] sig_rev;
  for (genvar i = 0; i < SIG_BITS; i++) begin : g_rev
    assign sig_rev[i] = sig_abcd[SIG_BITS-1-i];
  end

  logic [SIDX_W-1:0] sig_k;
  logic              sig_frame;
  logic [7:0]        rbs_b, yel_b, zcs_b, nxt_b;
  logic              zcs_on;

  assign sig_k     = SIDX_W'(frame_num / FRM_W'(SIG_PERIOD));
  assign sig_frame = (frame_num % FRM_W'(SIG_PERIOD)) == FRM_W'(SIG_PERIOD - 1);
  assign rbs_b     = (sig_frame && !ctl_rbs_dis) ? {ch_in[7:1], sig_rev[sig_k]} : ch_in;
  assign yel_b     = ctl_yellow ? (rbs_b & 8'hBF) : rbs_b;
  assign zcs_on    = !ctl_transparent && !ctl_b8zs;
  assign zcs_b     = (zcs_on && yel_b == 8'h00) ? 8'h02 : yel_b;
  assign nxt_b     = ctl_all_ones ? 8'hFF : zcs_b;
  assign b8zs_en   = ctl_b8zs && !ctl_transparent;

  logic             yel_act, yel_prev;
  logic [CNT_W-1:0] yel_cnt, yel_pos;

  assign yel_act = ctl_esf && ctl_esf_yellow;
  assign yel_pos = (yel_act && !yel_prev) ? '0 : yel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      tx_byte   <= 8'hFF;
      fdl_out   <= 1'b1;
      yel_prev  <= 1'b0;
      yel_cnt   <= '0;
    end else begin
      out_valid <= in_valid;
      yel_prev  <= yel_act;
      if (in_valid) tx_byte <= nxt_b;
      if (fdl_slot) begin
        fdl_out <= ctl_all_ones ? 1'b1 :
                   yel_act      ? (yel_pos < CNT_W'(YEL_RUN)) : fdl_in;
        if (yel_act)
          yel_cnt <= (yel_pos == CNT_W'(2 * YEL_RUN - 1)) ? '0 : yel_pos + CNT_W'(1);
      end else if (yel_act && !yel_prev) begin
        yel_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ds0_tx_conditioner_chk.sv
module ds0_tx_conditioner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] ch_in,
  input logic       ctl_rbs_dis,
  input logic       ctl_yellow,
  input logic       ctl_transparent,
  input logic       ctl_b8zs,
  input logic       ctl_all_ones,
  input logic       fdl_slot,
  input logic       out_valid,
  input logic [7:0] tx_byte,
  input logic       fdl_out
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  fdl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fdl_slot |=> $stable(fdl_out));
  // R8
  all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctl_all_ones |=> tx_byte == 8'hFF);
  // R3
  yellow_bit2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctl_yellow && !ctl_all_ones |=> !tx_byte[6]);
  // R4
  no_zero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ctl_all_ones && !ctl_transparent && !ctl_b8zs |=> tx_byte != 8'h00);
  // R1
  rbs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctl_rbs_dis && !ctl_all_ones |=> tx_byte[0] == $past(ch_in[0]));
  // R5
  transparent_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctl_transparent && ctl_rbs_dis && !ctl_yellow && !ctl_all_ones
    |=> tx_byte == $past(ch_in));
  // R6
  b8zs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctl_b8zs && !ctl_transparent && ctl_rbs_dis && !ctl_yellow && !ctl_all_ones
    |=> tx_byte == $past(ch_in));
endmodule

bind ds0_tx_conditioner ds0_tx_conditioner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ch_in(ch_in),
  .ctl_rbs_dis(ctl_rbs_dis), .ctl_yellow(ctl_yellow),
  .ctl_transparent(ctl_transparent), .ctl_b8zs(ctl_b8zs),
  .ctl_all_ones(ctl_all_ones), .fdl_slot(fdl_slot),
  .out_valid(out_valid), .tx_byte(tx_byte), .fdl_out(fdl_out)
);

// File: tb/sim_ds0_tx_conditioner.sv
module sim_ds0_tx_conditioner;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [7:0] ch_in = 0;
  logic [4:0] frame_num = 0;
  logic [3:0] sig_abcd = 0;
  logic ctl_rbs_dis = 0, ctl_yellow = 0, ctl_transparent = 0, ctl_b8zs = 0;
  logic ctl_esf = 0, ctl_esf_yellow = 0, ctl_all_ones = 0;
  logic fdl_slot = 0, fdl_in = 0;
  logic out_valid, fdl_out, b8zs_en;
  logic [7:0] tx_byte;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  ds0_tx_conditioner u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ch_in(ch_in),
    .frame_num(frame_num), .sig_abcd(sig_abcd), .ctl_rbs_dis(ctl_rbs_dis),
    .ctl_yellow(ctl_yellow), .ctl_transparent(ctl_transparent),
    .ctl_b8zs(ctl_b8zs), .ctl_esf(ctl_esf), .ctl_esf_yellow(ctl_esf_yellow),
    .ctl_all_ones(ctl_all_ones), .fdl_slot(fdl_slot), .fdl_in(fdl_in),
    .out_valid(out_valid), .tx_byte(tx_byte), .fdl_out(fdl_out), .b8zs_en(b8zs_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int c, input int f, input int sg, input int b);
    int r = b;
    if (f % 6 == 5 && (c & 1) == 0) r = (r & 254) | ((sg >> (3 - f / 6)) & 1);
    if ((c & 2) != 0) r = r & 191;
    if ((c & 4) == 0 && (c & 8) == 0 && r == 0) r = 2;
    if ((c & 16) != 0) r = 255;
    return 8'(r);
  endfunction

  task automatic slot(input logic din, input logic exp, input string tag);
    @(negedge clk); fdl_slot = 1; fdl_in = din;
    @(negedge clk); fdl_slot = 0; fdl_in = ~din;
    chk(tag, 32'(fdl_out), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'h01, 8'h40, 8'h41, 8'hFF, 8'h5A};
    repeat (3) @(negedge clk);
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 tx_byte", 32'(tx_byte), 32'hFF);
    chk("R10 fdl_out", 32'(fdl_out), 1);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R8 sweep over byte-affecting controls
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 24; f++) begin
        for (int p = 0; p < 6; p++) begin
          int sg = (f * 5 + c + p) & 15;
          @(negedge clk);
          ctl_rbs_dis = c[0]; ctl_yellow = c[1]; ctl_transparent = c[2];
          ctl_b8zs = c[3]; ctl_all_ones = c[4];
          frame_num = 5'(f); sig_abcd = 4'(sg); ch_in = pats[p]; in_valid = 1;
          #1 chk("R5 R6 b8zs_en", 32'(b8zs_en), 32'(c[3] && !c[2]));
          @(negedge clk); in_valid = 0;
          chk("R9 out_valid", 32'(out_valid), 1);
          chk("R1 R2 R3 R4 R8 tx_byte", 32'(tx_byte), 32'(exp_byte(c, f, sg, int'(pats[p]))));
        end
      end
    end
    @(negedge clk);
    chk("R9 out_valid idle", 32'(out_valid), 0);

    ctl_all_ones = 0; ctl_rbs_dis = 0; ctl_yellow = 0; ctl_transparent = 0; ctl_b8zs = 0;
    ctl_esf = 1; ctl_esf_yellow = 0;
    slot(1, 1, "R7 pass one");
    slot(0, 0, "R7 pass zero");
    @(negedge clk); fdl_in = 1;
    @(negedge clk);
    chk("R9 fdl hold", 32'(fdl_out), 0);

    @(negedge clk); ctl_esf_yellow = 1;
    for (int i = 0; i < 40; i++) begin
      slot(i[0], (i % 16) < 8, "R7 pattern");
      repeat (i % 3) @(negedge clk);
    end
    @(negedge clk); ctl_esf_yellow = 0;
    slot(0, 0, "R7 pass after alarm");
    @(negedge clk); ctl_esf_yellow = 1;
    for (int i = 0; i < 11; i++) slot(1, (i % 16) < 8, "R7 pattern b");
    @(negedge clk); ctl_esf_yellow = 0;
    @(negedge clk); ctl_esf_yellow = 1;
    for (int i = 0; i < 20; i++) slot(i[1], (i % 16) < 8, "R7 restart");

    ctl_esf = 0;
    slot(0, 0, "R7 non-esf passes fdl_in");
    slot(1, 1, "R7 non-esf passes fdl_in");
    ctl_all_ones = 1;
    slot(0, 1, "R8 fdl ones");
    ctl_all_ones = 0; ctl_transparent = 1; ctl_b8zs = 1;
    @(negedge clk); #1 chk("R5 b8zs_en", 32'(b8zs_en), 0);
    ch_in = 8'h00; frame_num = 0; in_valid = 1;
    @(negedge clk); in_valid = 0;
    chk("R5 zero byte kept", 32'(tx_byte), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule